// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register port. It counts strobes from one of four low-rate tick sources and raises a one-cycle reset request when the count reaches a programmed limit. Software keeps the system alive by writing a refresh key to the counter address. A separate unlock key opens a short window. Only inside that window can the control word or the timeout limit be rewritten.

The keys are written to the counter offset, either as two 16-bit halves or, once 32-bit command mode is on, as one combined word. Two read-only flags in the control word report state to software. One shows that the unlock window is open, so software polls it before reconfiguring. The other shows that a new configuration has taken effect, so software polls it afterwards. Two sleep inputs can freeze the count unless the matching keep-running bit is set. Clearing the update-permit bit in a committed control word makes the configuration permanent until reset.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the control word reads 0x00000020 (only the update-permit bit 5 set), the counter reads 0, the timeout register reads TO_RST (default 1000) and rst_req is 0.
- R2: In 16-bit mode, writing 0xC520 and then 0xD928 (low 16 bits; upper bits ignored) to offset 0x4 sets the unlocked flag, control bit 11, on the next cycle.
- R3: In 16-bit mode the second key word must be the very next write to offset 0x4. Any other value written to that offset in between discards the first word, and neither unlock nor refresh happens. Writes to other offsets do not affect key matching.
- R4: When control bit 13 is 1, a single write of 0xD928C520 to offset 0x4 unlocks and a single write of 0xB480A602 refreshes. The 16-bit halves written one after the other then have no effect.
- R5: Writes to the control word (offset 0x0) or the timeout register (offset 0x8) made while the unlocked flag is 0 are ignored.
- R6: The unlock window stays open for exactly WIN_CYC (default 128) cycles after the key is accepted. An accepted control-word write closes it at once. A timeout write leaves it open.
- R7: The reconfiguration-complete flag (control bit 10) clears when an unlock is accepted. It sets in the cycle after an accepted control or timeout write.
- R8: If a committed control word has bit 5 equal to 0, every later unlock key is ignored until reset.
- R9: While enabled (bit 7), each selected tick that finds the counter below the timeout adds one to it. A selected tick that finds the counter equal to or above the timeout clears it to 0 and pulses rst_req high for one cycle.
- R10: A refresh key clears the counter to 0.
- R11: Control bits 9:8 select which src_tick bit drives the count. Strobes on the other tick inputs do not count.
- R12: The counter holds while sleep_stop is 1 and bit 0 is 0, or while sleep_wait is 1 and bit 1 is 0. When the matching bit is 1, the count continues.
- R13: While the enable bit is 0 the counter is held at 0. Setting the bit again restarts counting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_tick | input | 4 | One-cycle strobes from the four tick sources |
| sleep_wait | input | 1 | Wait-mode sleep indication |
| sleep_stop | input | 1 | Stop-mode sleep indication |
| rst_req | output | 1 | One-cycle reset request to the reset controller |

## Verification
The bench breaks key pairs with a stray counter write. A design that kept the first half pending would then unlock or refresh when it should not. It also sends 16-bit halves in 32-bit mode, which a design that did not switch modes would accept. The window is measured to the exact cycle on both sides of its closing edge, which catches an off-by-one in the window counter. A timeout written while the window is open must not close it, and one written after it closes must not land. The bench lowers the timeout below the running count, so a design that compared only for equality would never fire. It also strobes unselected tick sources and holds each sleep input with and without its keep-running bit, which exposes a wrong source mux or halt polarity. The last test commits a control word with updates forbidden and shows that no later key reopens the window.

// File: rtl/wdg_pkg.sv
// Package: shared constants and types of the keyed-access watchdog.
// Assumes a 32-bit data bus; bit positions are the ones software relies on.
package wdg_pkg;
    localparam int NSRC = 4;
    localparam int SEL_W = $clog2(NSRC);

    localparam int OFS_CTRL = 'h0;
    localparam int OFS_CNT  = 'h4;
    localparam int OFS_TOV  = 'h8;

    localparam logic [15:0] UNL_LO = 16'hC520;
    localparam logic [15:0] UNL_HI = 16'hD928;
    localparam logic [15:0] REF_LO = 16'hA602;
    localparam logic [15:0] REF_HI = 16'hB480;
    localparam logic [31:0] UNL_WORD = {UNL_HI, UNL_LO};
    localparam logic [31:0] REF_WORD = {REF_HI, REF_LO};

    localparam int B_CMD32 = 13;
    localparam int B_UNL   = 11;
    localparam int B_DONE  = 10;
    localparam int B_SEL   = 8;
    localparam int B_EN    = 7;
    localparam int B_UPD   = 5;
    localparam int B_WAIT  = 1;
    localparam int B_STOP  = 0;

    typedef struct packed {
        logic             cmd32;
        logic [SEL_W-1:0] clksel;
        logic             en;
        logic             upd;
        logic             waiten;
        logic             stopen;
    } wdg_cfg_t;
endpackage

// File: rtl/wdg_keyseq.sv
// Module: key detector on writes to the counter offset.
// Yields single-cycle unlock and refresh pulses; assumes cnt_wr is a one-cycle strobe.
module wdg_keyseq
    import wdg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cnt_wr,
    input  logic [31:0] wdata,
    input  logic        cmd32,
    output logic        unl_p,
    output logic        ref_p
);
    logic pend_u, pend_r;
    logic [15:0] lo;

    assign lo = wdata[15:0];

    // Decode a completed key from the current write and the pending first half
    always_comb begin
        unl_p = 1'b0;
        ref_p = 1'b0;
        if (cnt_wr) begin
            if (cmd32) begin
                unl_p = (wdata == UNL_WORD);
                ref_p = (wdata == REF_WORD);
            end else begin
                unl_p = pend_u && (lo == UNL_HI);
                ref_p = pend_r && (lo == REF_HI);
            end
        end
    end

    // Remember which first half, if any, the last counter write carried
    always_ff @(posedge clk) begin
        if (!rst_n || cmd32) begin
            pend_u <= 1'b0;
            pend_r <= 1'b0;
        end else if (cnt_wr) begin
            pend_u <= (lo == UNL_LO);
            pend_r <= (lo == REF_LO);
        end
    end

    // R3: a 16-bit unlock completes only right after its first half
    assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (unl_p && !cmd32) |-> pend_u);
    // R3: refresh likewise needs its first half pending
    assert_ref_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_p && !cmd32) |-> pend_r);
endmodule

// File: rtl/wdg_cfg.sv
// Module: configuration registers, unlock window, lockout and completion flag.
// Assumes ctrl_wr and tov_wr never coincide with unl_p (one bus write per cycle).
module wdg_cfg
    import wdg_pkg::*;
#(
    parameter int TO_W    = 16,
    parameter int WIN_CYC = 128,
    parameter int TO_RST  = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_wr,
    input  logic            tov_wr,
    input  wdg_cfg_t        cfg_d,
    input  logic [TO_W-1:0] tov_d,
    input  logic            unl_p,
    output wdg_cfg_t        cfg_q,
    output logic [TO_W-1:0] tov_q,
    output logic            unl_q,
    output logic            done_q
);
    localparam int WIN_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
    localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN_CYC - 1);
    localparam wdg_cfg_t CFG_RST = '{cmd32: 1'b0, clksel: '0, en: 1'b0,
                                     upd: 1'b1, waiten: 1'b0, stopen: 1'b0};

    logic [WIN_W-1:0] win_q;
    logic lock_q;
    logic open_w, acc_c, acc_t;

    assign open_w = unl_p && !lock_q;
    assign acc_c  = unl_q && ctrl_wr;
    assign acc_t  = unl_q && tov_wr;

    // Open, time out or close the unlock window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unl_q <= 1'b0;
            win_q <= '0;
        end else if (open_w) begin
            unl_q <= 1'b1;
            win_q <= WIN_LOAD;
        end else if (acc_c) begin
            unl_q <= 1'b0;
        end else if (unl_q) begin
            if (win_q == '0) unl_q <= 1'b0;
            else             win_q <= win_q - 1'b1;
        end
    end

    // Commit the control word and latch a permanent lockout when updates are forbidden
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RST;
            lock_q <= 1'b0;
        end else if (acc_c) begin
            cfg_q <= cfg_d;
            if (!cfg_d.upd) lock_q <= 1'b1;
        end
    end

    // Commit the timeout limit
    always_ff @(posedge clk) begin
        if (!rst_n)     tov_q <= TO_W'(TO_RST);
        else if (acc_t) tov_q <= tov_d;
    end

    // Track whether the last unlock has been followed by an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)                done_q <= 1'b0;
        else if (open_w)           done_q <= 1'b0;
        else if (acc_c || acc_t)   done_q <= 1'b1;
    end

    // R5: nothing lands in the timeout or control registers while locked
    assert_locked_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !unl_q |=> ($stable(tov_q) && $stable(cfg_q)));
    // R6: a control write ends the window
    assert_close_on_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (unl_q && ctrl_wr) |=> !unl_q);
    // R7: a fresh window starts with the completion flag low
    assert_done_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unl_q) |-> !done_q);
    // R8: once locked out and closed, the window never reopens
    assert_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !unl_q) |=> !unl_q);
endmodule

// File: rtl/wdg_count.sv
// Module: tick-source select, sleep halt, counter and reset-request pulse.
// Assumes each src_tick strobe lasts one clock cycle.
module wdg_count
    import wdg_pkg::*;
#(
    parameter int TO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] clksel,
    input  logic             waiten,
    input  logic             stopen,
    input  logic [TO_W-1:0]  toval,
    input  logic [NSRC-1:0]  src_tick,
    input  logic             sleep_wait,
    input  logic             sleep_stop,
    input  logic             ref_p,
    output logic [TO_W-1:0]  cnt,
    output logic             rst_req
);
    logic halt, step;

    assign halt = (sleep_stop && !stopen) || (sleep_wait && !waiten);
    assign step = src_tick[clksel] && !halt;

    // Advance, clear or wrap the count and raise the reset request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (!en || ref_p) begin
                cnt <= '0;
            end else if (step) begin
                if (cnt >= toval) begin
                    cnt     <= '0;
                    rst_req <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R9: the request cycle always sees a wrapped counter
    assert_req_wraps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt == '0));
    // R10: refresh clears the count without a request
    assert_refresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ref_p) |=> ((cnt == '0) && !rst_req));
    // R12: a halted counter keeps its value
    assert_halt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (en && halt && !ref_p) |=> $stable(cnt));
    // R13: disabled means zero
    assert_disabled_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));
endmodule

// File: rtl/keyed_wdog.sv
// Module: top of the keyed-access watchdog; decodes the register port and
// joins key detection, configuration and counting. Reads are combinational.
module keyed_wdog
    import wdg_pkg::*;
#(
    parameter int AW      = 4,
    parameter int TO_W    = 16,
    parameter int WIN_CYC = 128,
    parameter int TO_RST  = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NSRC-1:0] src_tick,
    input  logic            sleep_wait,
    input  logic            sleep_stop,
    output logic            rst_req
);
    logic ctrl_wr, cnt_wr, tov_wr;
    logic unl_p, ref_p, unl_q, done_q;
    wdg_cfg_t cfg_d, cfg_q;
    logic [TO_W-1:0] tov_q, cnt;

    assign ctrl_wr = bus_wr && (bus_addr == AW'(OFS_CTRL));
    assign cnt_wr  = bus_wr && (bus_addr == AW'(OFS_CNT));
    assign tov_wr  = bus_wr && (bus_addr == AW'(OFS_TOV));

    assign cfg_d = '{cmd32:  bus_wdata[B_CMD32],
                     clksel: bus_wdata[B_SEL +: SEL_W],
                     en:     bus_wdata[B_EN],
                     upd:    bus_wdata[B_UPD],
                     waiten: bus_wdata[B_WAIT],
                     stopen: bus_wdata[B_STOP]};

    wdg_keyseq u_keys (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .wdata(bus_wdata),
        .cmd32(cfg_q.cmd32), .unl_p(unl_p), .ref_p(ref_p)
    );

    wdg_cfg #(.TO_W(TO_W), .WIN_CYC(WIN_CYC), .TO_RST(TO_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .tov_wr(tov_wr),
        .cfg_d(cfg_d), .tov_d(bus_wdata[TO_W-1:0]), .unl_p(unl_p),
        .cfg_q(cfg_q), .tov_q(tov_q), .unl_q(unl_q), .done_q(done_q)
    );

    wdg_count #(.TO_W(TO_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(cfg_q.en), .clksel(cfg_q.clksel),
        .waiten(cfg_q.waiten), .stopen(cfg_q.stopen), .toval(tov_q),
        .src_tick(src_tick), .sleep_wait(sleep_wait), .sleep_stop(sleep_stop),
        .ref_p(ref_p), .cnt(cnt), .rst_req(rst_req)
    );

    // Return the register selected by the address
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFS_CTRL)) begin
            bus_rdata[B_CMD32]         = cfg_q.cmd32;
            bus_rdata[B_UNL]           = unl_q;
            bus_rdata[B_DONE]          = done_q;
            bus_rdata[B_SEL +: SEL_W]  = cfg_q.clksel;
            bus_rdata[B_EN]            = cfg_q.en;
            bus_rdata[B_UPD]           = cfg_q.upd;
            bus_rdata[B_WAIT]          = cfg_q.waiten;
            bus_rdata[B_STOP]          = cfg_q.stopen;
        end else if (bus_addr == AW'(OFS_CNT)) begin
            bus_rdata = 32'(cnt);
        end else if (bus_addr == AW'(OFS_TOV)) begin
            bus_rdata = 32'(tov_q);
        end
    end
endmodule

// File: tb/keyed_wdog_test.sv
// Bench: directed scenarios for the keyed-access watchdog, one task each.
module keyed_wdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick = '0;
    logic        sleep_wait = 1'b0;
    logic        sleep_stop = 1'b0;
    logic        rst_req;
    int checks = 0;
    int errors = 0;

    keyed_wdog uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
        .sleep_wait(sleep_wait), .sleep_stop(sleep_stop), .rst_req(rst_req)
    );

    always #4 clk = ~clk;

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src_tick = '0; sleep_wait = 1'b0; sleep_stop = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic unlock16();
        wr(4'h4, 32'h0000C520);
        wr(4'h4, 32'h0000D928);
    endtask

    task automatic tick(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_tick[idx] = 1'b1;
            @(negedge clk);
            src_tick = '0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(4'h0, v); chk("R1 ctrl", v, 32'h20);
        rd(4'h4, v); chk("R1 cnt", v, 0);
        rd(4'h8, v); chk("R1 tov", v, 1000);
        chk("R1 rst_req", {31'd0, rst_req}, 0);
    endtask

    task automatic t_unlock16();
        logic [31:0] v;
        do_reset();
        unlock16();
        rd(4'h0, v); chk("R2 unlocked", v[11], 1); chk("R7 done low after unlock", v[10], 0);
        wr(4'h8, 32'd5);
        rd(4'h0, v); chk("R7 done after tov", v[10], 1); chk("R6 tov keeps window", v[11], 1);
        rd(4'h8, v); chk("R2 tov written", v, 5);
        wr(4'h0, 32'h20);
        rd(4'h0, v); chk("R6 ctrl closes", v[11], 0); chk("R7 done after ctrl", v[10], 1);
    endtask

    task automatic t_broken();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h0000C520); wr(4'h4, 32'h00001234); wr(4'h4, 32'h0000D928);
        rd(4'h0, v); chk("R3 broken pair", v[11], 0);
        wr(4'h4, 32'h0000C520); wr(4'h8, 32'd3); wr(4'h4, 32'h0000D928);
        rd(4'h0, v); chk("R3 other offset keeps pair", v[11], 1);
        rd(4'h8, v); chk("R5 tov before unlock ignored", v, 1000);
    endtask

    task automatic t_locked();
        logic [31:0] v;
        do_reset();
        wr(4'h8, 32'd7);
        wr(4'h0, 32'h000021A3);
        rd(4'h8, v); chk("R5 tov locked", v, 1000);
        rd(4'h0, v); chk("R5 ctrl locked", v, 32'h20);
    endtask

    task automatic t_window();
        logic [31:0] v;
        do_reset();
        unlock16();
        repeat (127) @(negedge clk);
        rd(4'h0, v); chk("R6 open at last cycle", v[11], 1);
        @(negedge clk);
        rd(4'h0, v); chk("R6 closed after window", v[11], 0);
        wr(4'h8, 32'd3);
        rd(4'h8, v); chk("R6 tov after window ignored", v, 1000);
    endtask

    task automatic t_cmd32();
        logic [31:0] v;
        do_reset();
        unlock16();
        wr(4'h0, 32'h00002020);
        unlock16();
        rd(4'h0, v); chk("R4 halves ignored in 32-bit", v[11], 0);
        wr(4'h4, 32'hD928C520);
        rd(4'h0, v); chk("R4 word unlock", v[11], 1);
        wr(4'h0, 32'h000021A0);
        tick(1, 3);
        rd(4'h4, v); chk("R4 count before refresh", v, 3);
        wr(4'h4, 32'hB480A602);
        rd(4'h4, v); chk("R4 word refresh", v, 0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        do_reset();
        unlock16();
        wr(4'h8, 32'd5);
        wr(4'h0, 32'h000001A0);
        tick(0, 2); tick(2, 1); tick(3, 1);
        rd(4'h4, v); chk("R11 other sources", v, 0);
        tick(1, 5);
        rd(4'h4, v); chk("R9 count five", v, 5);
        chk("R9 no early req", {31'd0, rst_req}, 0);
        tick(1, 1);
        chk("R9 req pulse", {31'd0, rst_req}, 1);
        rd(4'h4, v); chk("R9 wrap", v, 0);
        @(negedge clk);
        chk("R9 one cycle", {31'd0, rst_req}, 0);
        tick(1, 3);
        wr(4'h4, 32'h0000A602); wr(4'h4, 32'h0000B480);
        rd(4'h4, v); chk("R10 refresh16", v, 0);
        tick(1, 2);
        wr(4'h4, 32'h0000A602); wr(4'h4, 32'h00000000); wr(4'h4, 32'h0000B480);
        rd(4'h4, v); chk("R3 broken refresh", v, 2);
        unlock16();
        wr(4'h0, 32'h00000120);
        tick(1, 1);
        rd(4'h4, v); chk("R13 disabled zero", v, 0);
        unlock16();
        wr(4'h0, 32'h000001A0);
        tick(1, 4);
        rd(4'h4, v); chk("R13 restart", v, 4);
        unlock16();
        wr(4'h8, 32'd2);
        tick(1, 1);
        chk("R9 fire above limit", {31'd0, rst_req}, 1);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        do_reset();
        unlock16();
        wr(4'h8, 32'd100);
        wr(4'h0, 32'h000001A0);
        sleep_stop = 1'b1;
        tick(1, 3);
        rd(4'h4, v); chk("R12 stop halts", v, 0);
        sleep_stop = 1'b0; sleep_wait = 1'b1;
        tick(1, 2);
        rd(4'h4, v); chk("R12 wait halts", v, 0);
        unlock16();
        wr(4'h0, 32'h000001A3);
        sleep_stop = 1'b1;
        tick(1, 2);
        rd(4'h4, v); chk("R12 keep running", v, 2);
    endtask

    task automatic t_lockout();
        logic [31:0] v;
        do_reset();
        unlock16();
        wr(4'h0, 32'h00000000);
        rd(4'h0, v); chk("R8 upd cleared", v[5], 0);
        unlock16();
        rd(4'h0, v); chk("R8 unlock refused", v[11], 0);
        wr(4'h8, 32'd9);
        rd(4'h8, v); chk("R8 tov stays", v, 1000);
    endtask

    initial begin
        t_reset();
        t_unlock16();
        t_broken();
        t_locked();
        t_window();
        t_cmd32();
        t_count();
        t_halt();
        t_lockout();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule